// File: doc/BRIEF.md
# Priority-Based Clock Reference Switchover Controller

This block chooses which of eight clock references drives a downstream synthesis loop. Each reference arrives with a validity flag from an external monitor and two 3-bit priorities. The selection priority ranks the reference while it competes for the active slot. The promoted priority is the rank it defends with once it holds that slot. A lower number always means a more important reference.

A 2-bit mode field and a 3-bit user reference index set how much control software keeps. The block can run fully automatic, prefer a named reference and fall back to arbitration, prefer a named reference and otherwise coast in holdover, or follow the named reference without condition. Two override bits force holdover or free-run regardless of mode. All outputs are registered, so a decision reaches the outputs one clock after the inputs that caused it.

Top module: `refsw_ctrl`

## Requirements
- R1: While reset is low at a clock edge, act_ref becomes 0 and act_ok, in_hold, in_free and sw_pulse become 0.
- R2: In automatic mode (mode 2'b00), the active reference is the valid reference with the lowest selection priority, ties going to the lowest index, and user_ref has no effect.
- R3: In automatic mode, when the active reference loses validity, the block moves to the best remaining valid reference by the R2 rule.
- R4: A valid non-active reference takes over only when its selection priority is strictly lower than the promoted priority of the active reference; an equal or higher value leaves the active reference in place.
- R5: When a new reference is needed and none is valid, in_hold is 1 and act_ok is 0, act_ref keeps its last value, and the block leaves holdover as soon as any reference is valid.
- R6: In fallback mode (mode 2'b01), the user reference is active while valid; otherwise the R2/R3 arbitration picks the reference.
- R7: In holdover mode (mode 2'b10), the user reference is active while valid; otherwise the block is in holdover.
- R8: In manual mode (mode 2'b11), act_ref equals user_ref whether valid or not, in_hold is 0, and act_ok reflects that reference's validity.
- R9: With force_hold set and force_free clear, in_hold is 1, in_free is 0 and act_ok is 0.
- R10: With force_free set, in_free is 1 and in_hold is 0, even when force_hold is also set.
- R11: Every decision appears at the outputs one clock after its inputs; sw_pulse is 1 for exactly the cycle in which a reference is newly taken or a different reference becomes active.
- R12: in_hold and in_free are never both 1, and act_ok is never 1 while either is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ok | input | 8 | Validity flag per reference, bit i for reference i |
| sel_prio | input | 24 | Selection priorities, reference i in bits [3i+2:3i] |
| prom_prio | input | 24 | Promoted priorities, reference i in bits [3i+2:3i] |
| mode | input | 2 | 00 automatic, 01 fallback, 10 holdover, 11 manual |
| user_ref | input | 3 | Index of the user reference |
| force_hold | input | 1 | Force holdover |
| force_free | input | 1 | Force free-run, wins over force_hold |
| act_ref | output | 3 | Index of the active reference |
| act_ok | output | 1 | A reference is tracked and it was valid |
| in_hold | output | 1 | Holdover status |
| in_free | output | 1 | Free-run status |
| sw_pulse | output | 1 | One-cycle pulse when a reference is newly taken |

## Verification
On every cycle the assertions check that holdover and free-run never coincide, that act_ok never accompanies either, that the override bits land one clock later with free-run winning, that manual and preferred-user modes place the user index on act_ref, and that any change of act_ref while tracking carries sw_pulse. Arbitration order cannot be read from a single cycle's relation, so the bench's scenarios show lowest-priority selection with the lowest-index tie, the strict promoted-priority preemption threshold, failover to the next best reference, and entry into and exit from holdover.

// File: rtl/refsw_pkg.sv
// Package: shared encodings for the reference switchover controller.
// Assumes the mode field is exactly two bits wide.
package refsw_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO     = 2'b00,
        MODE_FALLBACK = 2'b01,
        MODE_HOLD     = 2'b10,
        MODE_MANUAL   = 2'b11
    } sw_mode_e;

endpackage

// File: rtl/refsw_arbiter.sv
// Module: refsw_arbiter
// Finds the candidate with the numerically lowest priority; on a tie the
// lowest index wins. Purely combinational. Assumes cand is already masked
// down to references that may be chosen.
module refsw_arbiter #(
    parameter int NUM_REFS = 8,
    parameter int PRIO_W   = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic [NUM_REFS-1:0]        cand,
    input  logic [NUM_REFS*PRIO_W-1:0] prio,
    output logic                       found,
    output logic [IDX_W-1:0]           win_idx,
    output logic [PRIO_W-1:0]          win_prio
);

    // Scan upward; strict compare keeps the earlier index on ties.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/refsw_decide.sv
// Module: refsw_decide
// Next-state decision for the switchover controller. Combines overrides,
// the user mode and the automatic arbitration result into the reference and
// status to register next. Assumes chal_* comes from an arbiter that
// excluded the currently tracked reference.
module refsw_decide
    import refsw_pkg::*;
#(
    parameter int NUM_REFS = 8,
    parameter int PRIO_W   = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic [NUM_REFS-1:0]        ref_ok,
    input  logic [NUM_REFS*PRIO_W-1:0] prom_prio,
    input  logic [1:0]                 mode,
    input  logic [IDX_W-1:0]           user_ref,
    input  logic                       force_hold,
    input  logic                       force_free,
    input  logic [IDX_W-1:0]           cur_ref,
    input  logic                       tracking,
    input  logic                       chal_found,
    input  logic [IDX_W-1:0]           chal_idx,
    input  logic [PRIO_W-1:0]          chal_prio,
    output logic [IDX_W-1:0]           nxt_ref,
    output logic                       nxt_track,
    output logic                       nxt_hold,
    output logic                       nxt_free
);

    logic              cur_ok;
    logic              user_ok;
    logic              auto_track;
    logic [IDX_W-1:0]  auto_ref;
    logic [PRIO_W-1:0] cur_prom;
    sw_mode_e          mode_e;

    assign mode_e   = sw_mode_e'(mode);
    assign cur_ok   = tracking && ref_ok[cur_ref];
    assign user_ok  = ref_ok[user_ref];
    assign cur_prom = prom_prio[cur_ref*PRIO_W +: PRIO_W];

    // Automatic result: defend with promoted priority, else take best valid.
    always_comb begin
        auto_track = 1'b0;
        auto_ref   = cur_ref;
        if (cur_ok) begin
            auto_track = 1'b1;
            if (chal_found && chal_prio < cur_prom) begin
                auto_ref = chal_idx;
            end
        end else if (chal_found) begin
            auto_track = 1'b1;
            auto_ref   = chal_idx;
        end
    end

    // Overrides first, then the selected mode.
    always_comb begin
        nxt_ref   = cur_ref;
        nxt_track = 1'b0;
        nxt_hold  = 1'b0;
        nxt_free  = 1'b0;
        if (force_free) begin
            nxt_free = 1'b1;
        end else if (force_hold) begin
            nxt_hold = 1'b1;
        end else begin
            unique case (mode_e)
                MODE_MANUAL: begin
                    nxt_ref   = user_ref;
                    nxt_track = 1'b1;
                end
                MODE_HOLD: begin
                    if (user_ok) begin
                        nxt_ref   = user_ref;
                        nxt_track = 1'b1;
                    end else begin
                        nxt_hold = 1'b1;
                    end
                end
                MODE_FALLBACK: begin
                    if (user_ok) begin
                        nxt_ref   = user_ref;
                        nxt_track = 1'b1;
                    end else begin
                        nxt_ref   = auto_ref;
                        nxt_track = auto_track;
                        nxt_hold  = !auto_track;
                    end
                end
                default: begin
                    nxt_ref   = auto_ref;
                    nxt_track = auto_track;
                    nxt_hold  = !auto_track;
                end
            endcase
        end
    end

endmodule

// File: rtl/refsw_ctrl.sv
// Module: refsw_ctrl (top)
// Selects one active clock reference out of NUM_REFS using four switchover
// modes and two-tier priorities. All outputs are registered: a decision
// shows one clock after the inputs that caused it. Assumes ref_ok and the
// priority buses are synchronous to clk.
module refsw_ctrl #(
    parameter int NUM_REFS = 8,
    parameter int PRIO_W   = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REFS-1:0]        ref_ok,
    input  logic [NUM_REFS*PRIO_W-1:0] sel_prio,
    input  logic [NUM_REFS*PRIO_W-1:0] prom_prio,
    input  logic [1:0]                 mode,
    input  logic [IDX_W-1:0]           user_ref,
    input  logic                       force_hold,
    input  logic                       force_free,
    output logic [IDX_W-1:0]           act_ref,
    output logic                       act_ok,
    output logic                       in_hold,
    output logic                       in_free,
    output logic                       sw_pulse
);

    logic [IDX_W-1:0]    cur_ref;
    logic                tracking;
    logic [NUM_REFS-1:0] cur_oh;
    logic [NUM_REFS-1:0] cand;
    logic                chal_found;
    logic [IDX_W-1:0]    chal_idx;
    logic [PRIO_W-1:0]   chal_prio;
    logic [IDX_W-1:0]    nxt_ref;
    logic                nxt_track;
    logic                nxt_hold;
    logic                nxt_free;

    // Candidates: valid references other than the one already tracked.
    assign cur_oh = {{(NUM_REFS-1){1'b0}}, 1'b1} << cur_ref;
    assign cand   = ref_ok & ~(tracking ? cur_oh : '0);

    refsw_arbiter #(
        .NUM_REFS (NUM_REFS),
        .PRIO_W   (PRIO_W)
    ) u_arb (
        .cand     (cand),
        .prio     (sel_prio),
        .found    (chal_found),
        .win_idx  (chal_idx),
        .win_prio (chal_prio)
    );

    refsw_decide #(
        .NUM_REFS (NUM_REFS),
        .PRIO_W   (PRIO_W)
    ) u_dec (
        .ref_ok     (ref_ok),
        .prom_prio  (prom_prio),
        .mode       (mode),
        .user_ref   (user_ref),
        .force_hold (force_hold),
        .force_free (force_free),
        .cur_ref    (cur_ref),
        .tracking   (tracking),
        .chal_found (chal_found),
        .chal_idx   (chal_idx),
        .chal_prio  (chal_prio),
        .nxt_ref    (nxt_ref),
        .nxt_track  (nxt_track),
        .nxt_hold   (nxt_hold),
        .nxt_free   (nxt_free)
    );

    // State and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ref  <= '0;
            tracking <= 1'b0;
            in_hold  <= 1'b0;
            in_free  <= 1'b0;
            act_ok   <= 1'b0;
            sw_pulse <= 1'b0;
        end else begin
            cur_ref  <= nxt_ref;
            tracking <= nxt_track;
            in_hold  <= nxt_hold;
            in_free  <= nxt_free;
            act_ok   <= nxt_track && ref_ok[nxt_ref];
            sw_pulse <= nxt_track && (!tracking || nxt_ref != cur_ref);
        end
    end

    assign act_ref = cur_ref;

endmodule

// File: rtl/refsw_ctrl_chk.sv
// Module: refsw_ctrl_chk
// Property checker for refsw_ctrl, attached by bind. Observes ports only.
module refsw_ctrl_chk #(
    parameter int NUM_REFS = 8,
    parameter int PRIO_W   = 3,
    localparam int IDX_W   = $clog2(NUM_REFS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_REFS-1:0] ref_ok,
    input logic [1:0]          mode,
    input logic [IDX_W-1:0]    user_ref,
    input logic                force_hold,
    input logic                force_free,
    input logic [IDX_W-1:0]    act_ref,
    input logic                act_ok,
    input logic                in_hold,
    input logic                in_free,
    input logic                sw_pulse
);

    // R12
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_hold && in_free));

    // R12
    ok_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |-> (!in_hold && !in_free));

    // R10
    free_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_free |=> (in_free && !in_hold && !act_ok));

    // R9
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hold && !force_free) |=> (in_hold && !in_free && !act_ok));

    // R8
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_hold && !force_free && mode == 2'b11)
        |=> (act_ref == $past(user_ref) && !in_hold && act_ok == $past(ref_ok[user_ref])));

    // R6
    user_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_hold && !force_free && (mode == 2'b01 || mode == 2'b10) && ref_ok[user_ref])
        |=> (act_ref == $past(user_ref) && act_ok));

    // R11
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ref != $past(act_ref) && !in_hold && !in_free) |-> sw_pulse);

endmodule

bind refsw_ctrl refsw_ctrl_chk #(
    .NUM_REFS (NUM_REFS),
    .PRIO_W   (PRIO_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_ok     (ref_ok),
    .mode       (mode),
    .user_ref   (user_ref),
    .force_hold (force_hold),
    .force_free (force_free),
    .act_ref    (act_ref),
    .act_ok     (act_ok),
    .in_hold    (in_hold),
    .in_free    (in_free),
    .sw_pulse   (sw_pulse)
);

// File: tb/refsw_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for refsw_ctrl: one task per scenario.
module refsw_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ref_ok = '0;
    logic [23:0] sel_prio = '1;
    logic [23:0] prom_prio = '1;
    logic [1:0]  mode = 2'b00;
    logic [2:0]  user_ref = '0;
    logic        force_hold = 1'b0;
    logic        force_free = 1'b0;
    logic [2:0]  act_ref;
    logic        act_ok;
    logic        in_hold;
    logic        in_free;
    logic        sw_pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    refsw_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_ok     (ref_ok),
        .sel_prio   (sel_prio),
        .prom_prio  (prom_prio),
        .mode       (mode),
        .user_ref   (user_ref),
        .force_hold (force_hold),
        .force_free (force_free),
        .act_ref    (act_ref),
        .act_ok     (act_ok),
        .in_hold    (in_hold),
        .in_free    (in_free),
        .sw_pulse   (sw_pulse)
    );

    // One clock edge, then back to the falling edge for sampling/driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int idx, input logic [2:0] s, input logic [2:0] p);
        sel_prio[idx*3 +: 3]  = s;
        prom_prio[idx*3 +: 3] = p;
    endtask

    // Compare {ref, ok, hold, free, pulse} against expected.
    task automatic expect_out(input string tag, input logic [2:0] e_ref, input logic e_ok,
                              input logic e_hold, input logic e_free, input logic e_pulse);
        logic [6:0] act, exp;
        act = {act_ref, act_ok, in_hold, in_free, sw_pulse};
        exp = {e_ref, e_ok, e_hold, e_free, e_pulse};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ref=%0d ok=%b hold=%b free=%b pulse=%b expected ref=%0d ok=%b hold=%b free=%b pulse=%b",
                     tag, act[6:4], act[3], act[2], act[1], act[0],
                     exp[6:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic t_reset();
        repeat (3) step();
        expect_out("R1 reset state", 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        expect_out("R5 none valid after reset", 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_auto_select();
        set_prio(0, 3'd5, 3'd5);
        set_prio(1, 3'd3, 3'd2);
        set_prio(2, 3'd3, 3'd3);
        set_prio(3, 3'd1, 3'd0);
        set_prio(4, 3'd2, 3'd2);
        set_prio(5, 3'd6, 3'd6);
        set_prio(6, 3'd6, 3'd6);
        set_prio(7, 3'd4, 3'd4);
        user_ref = 3'd6;
        ref_ok   = 8'b0100_0111;
        step();
        expect_out("R2 tie to lowest index, user ignored", 3'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        step();
        expect_out("R11 pulse lasts one cycle", 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_preempt();
        ref_ok[4] = 1'b1;
        step();
        expect_out("R4 equal to promoted keeps active", 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        ref_ok[3] = 1'b1;
        step();
        expect_out("R4 lower than promoted preempts", 3'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_failover();
        ref_ok[3] = 1'b0;
        step();
        expect_out("R3 failover to best remaining", 3'd4, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_holdover_auto();
        ref_ok = '0;
        step();
        expect_out("R5 enter holdover", 3'd4, 1'b0, 1'b1, 1'b0, 1'b0);
        ref_ok = 8'b0000_0100;
        step();
        expect_out("R5 leave holdover", 3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_fallback();
        mode     = 2'b01;
        user_ref = 3'd5;
        ref_ok   = 8'b0010_0101;
        step();
        expect_out("R6 user reference while valid", 3'd5, 1'b1, 1'b0, 1'b0, 1'b1);
        ref_ok[5] = 1'b0;
        step();
        expect_out("R6 user invalid falls back to arbitration", 3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_holdmode();
        mode     = 2'b10;
        user_ref = 3'd0;
        step();
        expect_out("R7 user reference while valid", 3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        ref_ok[0] = 1'b0;
        step();
        expect_out("R7 user invalid enters holdover", 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_manual();
        mode     = 2'b11;
        user_ref = 3'd7;
        step();
        expect_out("R8 manual follows invalid user", 3'd7, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_force();
        force_hold = 1'b1;
        step();
        expect_out("R9 forced holdover", 3'd7, 1'b0, 1'b1, 1'b0, 1'b0);
        force_free = 1'b1;
        step();
        expect_out("R10 free-run beats holdover", 3'd7, 1'b0, 1'b0, 1'b1, 1'b0);
        force_hold = 1'b0;
        force_free = 1'b0;
        ref_ok[7]  = 1'b1;
        step();
        expect_out("R11 resume tracking pulses", 3'd7, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_auto_select();
        t_preempt();
        t_failover();
        t_holdover_auto();
        t_fallback();
        t_holdmode();
        t_manual();
        t_force();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule